// File: doc/BRIEF.md
# Prefix-extended instruction decoder

This block turns a fetched 15-bit instruction word into an operation select. Each word holds a 3-bit opcode in its top bits and a 12-bit address in its low bits. A one-hot vector names the operation. Beside it the block drives the effective address and two control flags: one requests a return-address save, the other marks the count-compare-skip operation. The decode is combinational and is valid in the cycle in which `fetch_valid_i` is high.

Two pieces of state change how a word is read. The first is an escape prefix: a transfer-control word whose address equals `EXT_ADDR` does not jump. It arms a one-shot flag, and the next instruction is decoded from a second, extracode table. That table holds multiply, divide and subtract. The second is the index instruction: it captures `index_val_i`, and that value is added to the next instruction word before the word is decoded. A prefix placed between the index and its target leaves the addend pending. The execution units, memory banking and memory itself sit outside this block.

Top module: `instr_prefix_decoder`

## Requirements
- R1: After reset, neither the prefix flag nor an index addend is pending. The first word is decoded from the basic table without modification.
- R2: In the basic table, opcodes 0 to 7 select op_sel bits 0 to 7. These are, in order: transfer-control, count-compare-skip, index, exchange, clear-and-subtract, transfer-to-storage, add and mask. eff_addr_o equals bits 11:0 of the decoded word.
- R3: With no prefix pending, a raw word of opcode 0 and address `EXT_ADDR` (default 0x006) is the prefix. It raises prefix_o, with op_sel_o, eff_addr_o, save_ret_o and illegal_o all zero.
- R4: In the extracode table, opcode 4 selects multiply (op_sel bit 8), 5 selects divide (bit 9) and 6 selects subtract (bit 10). Every other opcode raises illegal_o, with op_sel_o and eff_addr_o zero.
- R5: A prefix applies to exactly one following decoded word, legal or illegal. Decoding then returns to the basic table. A prefix word is not recognized while a prefix is pending.
- R6: An index word captures index_val_i at its fetch. The next non-prefix word is replaced by the sum of the word and the captured value, modulo 2^15, before opcode and address are taken.
- R7: The addend is consumed by exactly one decoded word. A prefix word between them is not modified and keeps the addend pending.
- R8: save_ret_o is high exactly when transfer-control is selected. skip_o is high exactly when count-compare-skip is selected.
- R9: While fetch_valid_i is low, every output is zero and the pending state does not change.
- R10: Op_sel bits 8 to 10 are never driven from the basic table. Basic opcodes 4 to 6 always select clear-and-subtract, transfer-to-storage and add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetched word is present this cycle |
| fetch_word_i | input | 15 | Fetched instruction word |
| index_val_i | input | 15 | Value captured by an index instruction |
| op_sel_o | output | 11 | One-hot operation select |
| eff_addr_o | output | 12 | Effective address of the decoded word |
| prefix_o | output | 1 | Word is the escape prefix |
| save_ret_o | output | 1 | Save return address (transfer-control) |
| skip_o | output | 1 | Count-compare-skip selected |
| illegal_o | output | 1 | Undefined extracode |

## Verification
A prefix flag left set shows up on the very next valid fetch. A basic opcode then raises illegal_o, or opcodes 4 to 6 come out as the extracode bits. A flag that is lost shows as a basic operation where the extracode table was due. A stale or missing index addend is visible at once in eff_addr_o, and when the carry reaches bit 12, in the opcode as well. The bench runs a model in lockstep and compares every output on every fetch, so any such fault is reported within one fetch of its cause.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int NUM_OPS  = 11;
  localparam int OP_TC    = 0;
  localparam int OP_CCS   = 1;
  localparam int OP_INDEX = 2;
  localparam int OP_XCH   = 3;
  localparam int OP_CS    = 4;
  localparam int OP_TS    = 5;
  localparam int OP_AD    = 6;
  localparam int OP_MASK  = 7;
  localparam int OP_MP    = 8;
  localparam int OP_DV    = 9;
  localparam int OP_SU    = 10;

  typedef logic [NUM_OPS-1:0] op_sel_t;
endpackage

// File: rtl/idx_adder.sv
module idx_adder #(
  parameter int WORD_W = 15
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] addend_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb word_o = en_i ? word_i + addend_i : word_i;
endmodule

// File: rtl/op_table.sv
module op_table
  import instr_dec_pkg::*;
#(
  parameter int OPC_W     = 3,
  parameter bit EXT_TABLE = 1'b0
) (
  input  logic [OPC_W-1:0] opc_i,
  output op_sel_t          sel_o,
  output logic             legal_o
);
  generate
    if (EXT_TABLE) begin : g_ext
      always_comb begin
        sel_o   = '0;
        legal_o = 1'b1;
        case (int'(opc_i))
          4:       sel_o[OP_MP] = 1'b1;
          5:       sel_o[OP_DV] = 1'b1;
          6:       sel_o[OP_SU] = 1'b1;
          default: legal_o = 1'b0;
        endcase
      end
    end else begin : g_basic
      always_comb begin
        sel_o   = op_sel_t'(1) << opc_i;
        legal_o = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/dec_state.sv
module dec_state #(
  parameter int WORD_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              ext_d_i,
  input  logic              pend_d_i,
  input  logic              idx_ld_i,
  input  logic [WORD_W-1:0] idx_d_i,
  output logic              ext_o,
  output logic              pend_o,
  output logic [WORD_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_o  <= 1'b0;
      pend_o <= 1'b0;
      idx_o  <= '0;
    end else if (upd_i) begin
      ext_o  <= ext_d_i;
      pend_o <= pend_d_i;
      if (idx_ld_i) idx_o <= idx_d_i;
    end
  end
endmodule

// File: rtl/instr_prefix_decoder.sv
module instr_prefix_decoder
  import instr_dec_pkg::*;
#(
  parameter int              OPC_W    = 3,
  parameter int              ADDR_W   = 12,
  parameter int              WORD_W   = OPC_W + ADDR_W,
  parameter logic [ADDR_W-1:0] EXT_ADDR = 12'h006
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [WORD_W-1:0]  fetch_word_i,
  input  logic [WORD_W-1:0]  index_val_i,
  output logic [NUM_OPS-1:0] op_sel_o,
  output logic [ADDR_W-1:0]  eff_addr_o,
  output logic               prefix_o,
  output logic               save_ret_o,
  output logic               skip_o,
  output logic               illegal_o
);
  localparam logic [WORD_W-1:0] EXT_WORD = {{OPC_W{1'b0}}, EXT_ADDR};

  logic              ext_q, pend_q;
  logic [WORD_W-1:0] idx_q, mod_word;
  logic [OPC_W-1:0]  opc;
  logic              is_ext, dec, legal, basic_legal, ext_legal;
  op_sel_t           basic_sel, ext_sel, sel;

  // prefix is matched on the raw word so a pending addend cannot hide or fake it
  assign is_ext = !ext_q && (fetch_word_i == EXT_WORD);
  assign dec    = fetch_valid_i && !is_ext;

  idx_adder #(.WORD_W(WORD_W)) u_add (
    .word_i  (fetch_word_i),
    .addend_i(idx_q),
    .en_i    (pend_q),
    .word_o  (mod_word)
  );

  assign opc = mod_word[WORD_W-1 -: OPC_W];

  op_table #(.OPC_W(OPC_W), .EXT_TABLE(1'b0)) u_basic (
    .opc_i(opc), .sel_o(basic_sel), .legal_o(basic_legal)
  );
  op_table #(.OPC_W(OPC_W), .EXT_TABLE(1'b1)) u_ext (
    .opc_i(opc), .sel_o(ext_sel), .legal_o(ext_legal)
  );

  assign sel   = ext_q ? ext_sel   : basic_sel;
  assign legal = ext_q ? ext_legal : basic_legal;

  always_comb begin
    op_sel_o   = (dec && legal) ? sel : '0;
    eff_addr_o = (dec && legal) ? mod_word[ADDR_W-1:0] : '0;
    illegal_o  = dec && !legal;
    prefix_o   = fetch_valid_i && is_ext;
    save_ret_o = op_sel_o[OP_TC];
    skip_o     = op_sel_o[OP_CCS];
  end

  logic pend_d, idx_ld;
  assign idx_ld = op_sel_o[OP_INDEX];
  assign pend_d = is_ext ? pend_q : idx_ld;

  dec_state #(.WORD_W(WORD_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (fetch_valid_i),
    .ext_d_i (is_ext),
    .pend_d_i(pend_d),
    .idx_ld_i(idx_ld),
    .idx_d_i (index_val_i),
    .ext_o   (ext_q),
    .pend_o  (pend_q),
    .idx_o   (idx_q)
  );
endmodule

// File: rtl/instr_dec_chk.sv
module instr_dec_chk
  import instr_dec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fetch_valid_i,
  input logic [NUM_OPS-1:0] op_sel_o,
  input logic [ADDR_W-1:0]  eff_addr_o,
  input logic               prefix_o,
  input logic               save_ret_o,
  input logic               skip_o,
  input logic               illegal_o
);
  logic last_prefix;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            last_prefix <= 1'b0;
    else if (fetch_valid_i) last_prefix <= prefix_o;
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_sel_o));
  // R4
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (op_sel_o == '0 && eff_addr_o == '0 && last_prefix));
  // R10
  ext_ops_after_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_o[OP_SU:OP_MP] != '0) |-> last_prefix);
  // R5
  no_double_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefix_o |-> !last_prefix);
  // R3
  prefix_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefix_o |-> (op_sel_o == '0 && !save_ret_o && !illegal_o));
  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> (op_sel_o == '0 && !prefix_o && !illegal_o && eff_addr_o == '0));
  // R8
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_ret_o |-> (!skip_o && !illegal_o && !prefix_o));
endmodule

bind instr_prefix_decoder instr_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_valid_i(fetch_valid_i),
  .op_sel_o     (op_sel_o),
  .eff_addr_o   (eff_addr_o),
  .prefix_o     (prefix_o),
  .save_ret_o   (save_ret_o),
  .skip_o       (skip_o),
  .illegal_o    (illegal_o)
);

// File: tb/tb_instr_prefix_decoder.sv
module tb_instr_prefix_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [14:0] fetch_word_i = '0;
  logic [14:0] index_val_i = '0;
  logic [10:0] op_sel_o;
  logic [11:0] eff_addr_o;
  logic        prefix_o, save_ret_o, skip_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  bit        m_ext, m_pend;
  bit [14:0] m_idx;

  always #2.5 clk_i = ~clk_i;

  instr_prefix_decoder dut (
    .clk_i, .rst_ni, .fetch_valid_i, .fetch_word_i, .index_val_i,
    .op_sel_o, .eff_addr_o, .prefix_o, .save_ret_o, .skip_o, .illegal_o
  );

  task automatic step(input bit v, input bit [14:0] w, input bit [14:0] iv);
    bit [10:0] e_sel;
    bit [11:0] e_addr;
    bit        e_pfx, e_ill;
    bit [14:0] m;
    int        opc;
    string     req;
    bit [26:0] exp_v, act_v;
    @(negedge clk_i);
    fetch_valid_i = v; fetch_word_i = w; index_val_i = iv;
    #1;
    e_sel = '0; e_addr = '0; e_pfx = 0; e_ill = 0;
    m = m_pend ? w + m_idx : w;
    opc = int'(m[14:12]);
    req = "R2";
    if (!v) req = "R9";
    else if (!m_ext && w == 15'h0006) begin e_pfx = 1; req = m_pend ? "R7" : "R3"; end
    else begin
      if (m_ext) begin
        if (opc >= 4 && opc <= 6) begin e_sel[opc + 4] = 1; e_addr = m[11:0]; end
        else e_ill = 1;
        req = e_ill ? "R4" : (m_pend ? "R7" : "R5");
      end else begin
        e_sel[opc] = 1; e_addr = m[11:0];
        if (m_pend) req = "R6";
        else if (opc <= 1) req = "R8";
        else if (opc >= 4 && opc <= 6) req = "R10";
      end
    end
    exp_v = {e_sel, e_addr, e_pfx, e_sel[0], e_sel[1], e_ill};
    act_v = {op_sel_o, eff_addr_o, prefix_o, save_ret_o, skip_o, illegal_o};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s word=%h act=%h exp=%h", req, w, act_v, exp_v);
    end
    if (v) begin
      if (e_pfx) m_ext = 1;
      else begin
        m_ext = 0;
        if (!m_ext && e_sel[2]) begin m_pend = 1; m_idx = iv; end
        else m_pend = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; fetch_valid_i = 0;
    #1; m_ext = 0; m_pend = 0; m_idx = '0;
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    m_ext = 0; m_pend = 0; m_idx = '0;
    #1;
    // R1: reset state, outputs idle and first word decoded plainly
    checks++;
    if ({op_sel_o, prefix_o, illegal_o} !== '0) begin
      errors++; $display("FAIL R1 outputs in reset act=%h exp=0", {op_sel_o, prefix_o, illegal_o});
    end
    do_reset();
    step(1, 15'h6123, 15'h0011); // R1: basic AD, unmodified
    // R2 R8 R10: all basic opcodes across stepped addresses
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 4096; a += 61) step(1, {o[2:0], a[11:0]}, 15'(a * 3));
    // R4 R5: every extracode opcode after a prefix, then a basic word
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 16; a++) begin
        step(1, 15'h0006, '0);
        step(1, {o[2:0], 12'(a * 257)}, '0);
        step(1, {o[2:0], 12'(a)}, '0);
      end
    // R5: prefix word while prefix pending is an extracode (illegal opcode 0)
    step(1, 15'h0006, '0); step(1, 15'h0006, '0); step(1, 15'h0006, '0);
    // R6 R7: index then target, index-prefix-target, wrap of sum
    for (int k = 0; k < 64; k++) begin
      step(1, 15'h2000, 15'(k * 517));
      step(1, 15'(k * 1031), '0);
      step(1, 15'h2abc, 15'(k * 4099));
      step(1, 15'h0006, 15'h7fff);
      step(1, 15'(k * 333), '0);
      step(1, 15'h7fff, '0);
    end
    // R9: idle cycles between index and target leave state intact
    step(1, 15'h2000, 15'h1001);
    step(0, 15'h0006, 15'h0000);
    step(0, 15'h2000, 15'h7777);
    step(1, 15'h3005, '0);
    // R1: reset clears pending prefix and addend
    step(1, 15'h2000, 15'h4000);
    step(1, 15'h0006, '0);
    do_reset();
    step(1, 15'h4321, '0);
    // mixed pseudo-random traffic
    lfsr = 16'hace1;
    for (int n = 0; n < 20000; n++) begin
      bit [14:0] w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = lfsr[14:0];
      if (lfsr[2:0] == 3'd1) w = 15'h0006;
      step(lfsr[15] | lfsr[4], w, {lfsr[7:0], lfsr[15:9]});
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule